// File: doc/BRIEF.md
# Expansion Card Banked Memory Mapper

This block sits between a host's peripheral-slot bus and the memories of an expansion card. It decodes three host windows: a 16-entry register window, a small fixed window onto the card's driver code, and a 2 KB extra window. The extra window is split into two 1 KB pages. The lower page reaches one 1 KB page of an 8 KB static RAM, chosen by a RAM page register. The upper page reaches one 1 KB chunk of a 32 KB ROM image, chosen by a ROM page register.

The host loads both page registers through the register window. It can read them back, and the ROM page readback also carries the card's 3-bit device ID in its top bits. A further register offset reports the position of the card's physical DMA switch. The ROM and RAM arrays are outside the block. The mapper drives their addresses and the RAM write strobe, and it returns their data to the host.

Top module: `card_mem_mapper`

## Requirements
- R1: After reset the ROM page and the RAM page are 0 and the device ID is 7, so register offset 0xE reads 0xE0 and offset 0xF reads 0x00.
- R2: A read in the driver window presents rom_addr_o = addr_i[7:0] zero-extended, and rdata_o returns rom_data_i in the same cycle.
- R3: In the extra window with addr_i[10]=0, ram_addr_o = {ram_page, addr_i[9:0]}, and a read returns ram_rdata_i in the same cycle.
- R4: In the extra window with addr_i[10]=1, rom_addr_o = {rom_page, addr_i[9:0]}, and a read returns rom_data_i in the same cycle.
- R5: A register write to offset 0xE loads the ROM page from wdata_i[4:0] at the next clock edge. Bits 7:5 are ignored.
- R6: A register write to offset 0xF loads the RAM page from wdata_i[2:0] at the next clock edge. The upper bits are ignored.
- R7: A register read of offset 0xE returns the device ID in bits 7:5 and the ROM page in bits 4:0.
- R8: A register read of offset 0xC returns 0x10, with bit 6 also set when dma_sw_i is high.
- R9: A register read of offset 0xF returns the RAM page in bits 2:0 with zeros above it. All other register offsets read 0x00.
- R10: ram_we_o is high only in a cycle with ext_sel_i, wr_i and addr_i[10]=0, with ram_wdata_o = wdata_i. A write into the ROM page changes no RAM content.
- R11: rdata_o is 0x00 whenever rd_i is low or no window is selected.
- R12: Register writes to offsets other than 0xE and 0xF leave both page registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 11 | Host address offset within the selected window |
| wdata_i | input | 8 | Host write data |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe |
| reg_sel_i | input | 1 | Register window select (highest priority) |
| drv_sel_i | input | 1 | Driver window select |
| ext_sel_i | input | 1 | Extra 2 KB window select (lowest priority) |
| dma_sw_i | input | 1 | Physical DMA switch state |
| rdata_o | output | 8 | Host read data |
| rom_addr_o | output | 15 | ROM array address |
| rom_data_i | input | 8 | ROM array data |
| ram_addr_o | output | 13 | Static RAM address |
| ram_wdata_o | output | 8 | Static RAM write data |
| ram_we_o | output | 1 | Static RAM write strobe, sampled by the array on the clock edge |
| ram_rdata_i | input | 8 | Static RAM read data |

## Verification
The bench builds the block with its default parameters: 5-bit ROM page, 3-bit RAM page, 10-bit page offset, 8-bit driver window and a device ID of 7. These values make every ROM page (0 to 31) and all eight RAM pages reachable in a short run. The bench writes a distinct pattern into each RAM page and reads it back after switching pages, which exposes any mix-up between the pages. Page-register values written with their unused upper bits set show whether those bits are truncated.

// File: rtl/card_map_pkg.sv
package card_map_pkg;
  typedef enum logic [2:0] {
    WIN_NONE,
    WIN_REG,
    WIN_DRV,
    WIN_RAM,
    WIN_BROM
  } win_e;

  localparam logic [3:0] OFS_DMA_SW   = 4'hC;
  localparam logic [3:0] OFS_ROM_PAGE = 4'hE;
  localparam logic [3:0] OFS_RAM_PAGE = 4'hF;
  localparam logic [7:0] DMA_RD_BASE  = 8'h10;
  localparam int         DMA_SW_BIT   = 6;
endpackage

// File: rtl/card_win_decode.sv
module card_win_decode
  import card_map_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int PAGE_AW = 10
) (
  input  logic              reg_sel_i,
  input  logic              drv_sel_i,
  input  logic              ext_sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output win_e              win_o
);
  // register window wins, then driver window, then extra window
  always_comb begin
    if (reg_sel_i)      win_o = WIN_REG;
    else if (drv_sel_i) win_o = WIN_DRV;
    else if (ext_sel_i) win_o = addr_i[PAGE_AW] ? WIN_BROM : WIN_RAM;
    else                win_o = WIN_NONE;
  end
endmodule

// File: rtl/card_page_regs.sv
module card_page_regs
  import card_map_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int REG_AW      = 4,
  parameter int ROM_PAGE_W  = 5,
  parameter int RAM_PAGE_W  = 3,
  parameter int DEV_ID_W    = 3,
  parameter int DEV_ID_RST  = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [REG_AW-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  dma_sw_i,
  output logic [ROM_PAGE_W-1:0] rom_page_o,
  output logic [RAM_PAGE_W-1:0] ram_page_o,
  output logic [DATA_W-1:0]     rd_data_o
);
  logic [ROM_PAGE_W-1:0] rom_page_q;
  logic [RAM_PAGE_W-1:0] ram_page_q;
  logic [DEV_ID_W-1:0]   dev_id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom_page_q <= '0;
      ram_page_q <= '0;
      dev_id_q   <= DEV_ID_W'(DEV_ID_RST);
    end else if (wr_en_i) begin
      if (reg_addr_i == OFS_ROM_PAGE[REG_AW-1:0]) rom_page_q <= wdata_i[ROM_PAGE_W-1:0];
      if (reg_addr_i == OFS_RAM_PAGE[REG_AW-1:0]) ram_page_q <= wdata_i[RAM_PAGE_W-1:0];
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (reg_addr_i)
      OFS_DMA_SW[REG_AW-1:0]: begin
        rd_data_o             = DATA_W'(DMA_RD_BASE);
        rd_data_o[DMA_SW_BIT] = dma_sw_i;
      end
      OFS_ROM_PAGE[REG_AW-1:0]: begin
        rd_data_o[ROM_PAGE_W-1:0]         = rom_page_q;
        rd_data_o[DATA_W-1 -: DEV_ID_W]   = dev_id_q;
      end
      OFS_RAM_PAGE[REG_AW-1:0]: rd_data_o[RAM_PAGE_W-1:0] = ram_page_q;
      default: ;
    endcase
  end

  assign rom_page_o = rom_page_q;
  assign ram_page_o = ram_page_q;
endmodule

// File: rtl/card_addr_gen.sv
module card_addr_gen
  import card_map_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 11,
  parameter int PAGE_AW    = 10,
  parameter int DRV_AW     = 8,
  parameter int ROM_PAGE_W = 5,
  parameter int RAM_PAGE_W = 3,
  localparam int ROM_AW    = ROM_PAGE_W + PAGE_AW,
  localparam int RAM_AW    = RAM_PAGE_W + PAGE_AW
) (
  input  win_e                  win_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [ROM_PAGE_W-1:0] rom_page_i,
  input  logic [RAM_PAGE_W-1:0] ram_page_i,
  input  logic                  wr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [ROM_AW-1:0]     rom_addr_o,
  output logic [RAM_AW-1:0]     ram_addr_o,
  output logic                  ram_we_o,
  output logic [DATA_W-1:0]     ram_wdata_o
);
  logic [ROM_AW-1:0] drv_addr;
  logic [ROM_AW-1:0] page_addr;

  generate
    if (DRV_AW < ROM_AW) begin : g_drv_pad
      assign drv_addr = {{(ROM_AW-DRV_AW){1'b0}}, addr_i[DRV_AW-1:0]};
    end else begin : g_drv_full
      assign drv_addr = addr_i[ROM_AW-1:0];
    end
  endgenerate

  assign page_addr   = {rom_page_i, addr_i[PAGE_AW-1:0]};
  assign rom_addr_o  = (win_i == WIN_DRV) ? drv_addr : page_addr;
  assign ram_addr_o  = {ram_page_i, addr_i[PAGE_AW-1:0]};
  assign ram_we_o    = wr_i && (win_i == WIN_RAM);
  assign ram_wdata_o = wdata_i;
endmodule

// File: rtl/card_mem_mapper.sv
module card_mem_mapper
  import card_map_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 11,
  parameter int PAGE_AW    = 10,
  parameter int DRV_AW     = 8,
  parameter int REG_AW     = 4,
  parameter int ROM_PAGE_W = 5,
  parameter int RAM_PAGE_W = 3,
  parameter int DEV_ID_W   = 3,
  parameter int DEV_ID_RST = 7,
  localparam int ROM_AW    = ROM_PAGE_W + PAGE_AW,
  localparam int RAM_AW    = RAM_PAGE_W + PAGE_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              reg_sel_i,
  input  logic              drv_sel_i,
  input  logic              ext_sel_i,
  input  logic              dma_sw_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic [DATA_W-1:0] rom_data_i,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic              ram_we_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  win_e                  win;
  logic [ROM_PAGE_W-1:0] rom_page_q;
  logic [RAM_PAGE_W-1:0] ram_page_q;
  logic [DATA_W-1:0]     reg_rd;

  card_win_decode #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW)) u_dec (
    .reg_sel_i (reg_sel_i),
    .drv_sel_i (drv_sel_i),
    .ext_sel_i (ext_sel_i),
    .addr_i    (addr_i),
    .win_o     (win)
  );

  card_page_regs #(
    .DATA_W(DATA_W), .REG_AW(REG_AW), .ROM_PAGE_W(ROM_PAGE_W),
    .RAM_PAGE_W(RAM_PAGE_W), .DEV_ID_W(DEV_ID_W), .DEV_ID_RST(DEV_ID_RST)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_i && (win == WIN_REG)),
    .reg_addr_i (addr_i[REG_AW-1:0]),
    .wdata_i    (wdata_i),
    .dma_sw_i   (dma_sw_i),
    .rom_page_o (rom_page_q),
    .ram_page_o (ram_page_q),
    .rd_data_o  (reg_rd)
  );

  card_addr_gen #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW), .DRV_AW(DRV_AW),
    .ROM_PAGE_W(ROM_PAGE_W), .RAM_PAGE_W(RAM_PAGE_W)
  ) u_agen (
    .win_i       (win),
    .addr_i      (addr_i),
    .rom_page_i  (rom_page_q),
    .ram_page_i  (ram_page_q),
    .wr_i        (wr_i),
    .wdata_i     (wdata_i),
    .rom_addr_o  (rom_addr_o),
    .ram_addr_o  (ram_addr_o),
    .ram_we_o    (ram_we_o),
    .ram_wdata_o (ram_wdata_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (win)
        WIN_REG:           rdata_o = reg_rd;
        WIN_DRV, WIN_BROM: rdata_o = rom_data_i;
        WIN_RAM:           rdata_o = ram_rdata_i;
        default:           rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/card_mem_mapper_chk.sv
module card_mem_mapper_chk #(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 11,
  parameter int PAGE_AW    = 10,
  parameter int ROM_PAGE_W = 5,
  parameter int RAM_PAGE_W = 3
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [ADDR_W-1:0]            addr_i,
  input logic [DATA_W-1:0]            wdata_i,
  input logic                         wr_i,
  input logic                         reg_sel_i,
  input logic                         drv_sel_i,
  input logic                         ext_sel_i,
  input logic                         ram_we_o,
  input logic [RAM_PAGE_W+PAGE_AW-1:0] ram_addr_o,
  input logic [ROM_PAGE_W-1:0]        rom_page_q,
  input logic [RAM_PAGE_W-1:0]        ram_page_q
);
  logic reg_wr, rom_pg_wr, ram_pg_wr;
  assign reg_wr    = reg_sel_i && wr_i;
  assign rom_pg_wr = reg_wr && (addr_i[3:0] == 4'hE);
  assign ram_pg_wr = reg_wr && (addr_i[3:0] == 4'hF);

  // R10
  ram_we_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ext_sel_i && !reg_sel_i && !drv_sel_i && wr_i && !addr_i[PAGE_AW]));

  // R3
  ram_page_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_addr_o == {ram_page_q, addr_i[PAGE_AW-1:0]}));

  // R5
  rom_page_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_pg_wr |=> (rom_page_q == $past(wdata_i[ROM_PAGE_W-1:0])));

  // R6
  ram_page_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_pg_wr |=> (ram_page_q == $past(wdata_i[RAM_PAGE_W-1:0])));

  // R12
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rom_pg_wr || ram_pg_wr) |=> ($stable(rom_page_q) && $stable(ram_page_q)));
endmodule

bind card_mem_mapper card_mem_mapper_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW),
  .ROM_PAGE_W(ROM_PAGE_W), .RAM_PAGE_W(RAM_PAGE_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .wr_i       (wr_i),
  .reg_sel_i  (reg_sel_i),
  .drv_sel_i  (drv_sel_i),
  .ext_sel_i  (ext_sel_i),
  .ram_we_o   (ram_we_o),
  .ram_addr_o (ram_addr_o),
  .rom_page_q (rom_page_q),
  .ram_page_q (ram_page_q)
);

// File: tb/tb_card_mem_mapper.sv
`timescale 1ns/1ps
module tb_card_mem_mapper;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [10:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic        reg_sel_i = 1'b0, drv_sel_i = 1'b0, ext_sel_i = 1'b0;
  logic        dma_sw_i = 1'b0;
  logic [7:0]  rdata_o;
  logic [14:0] rom_addr_o;
  logic [7:0]  rom_data_i;
  logic [12:0] ram_addr_o;
  logic [7:0]  ram_wdata_o;
  logic        ram_we_o;
  logic [7:0]  ram_rdata_i;

  int vectors = 0;
  int miscompares = 0;
  string phase = "R1";
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  card_mem_mapper dut (.*);

  // external ROM image: computed pattern
  function automatic logic [7:0] rom_val(input int a);
    rom_val = 8'((a & 8'hFF) ^ (((a >> 10) & 31) * 7) ^ ((a >> 8) & 3));
  endfunction
  assign rom_data_i = rom_val(int'(rom_addr_o));

  // external static RAM array
  logic [7:0] ram_arr [0:8191];
  initial for (int i = 0; i < 8192; i++) ram_arr[i] = 8'h00;
  always @(posedge clk_i) if (ram_we_o) ram_arr[ram_addr_o] <= ram_wdata_o;
  assign ram_rdata_i = ram_arr[ram_addr_o];

  // reference model
  int m_rom_pg = 0, m_ram_pg = 0;
  int m_ram[int];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_rom_pg = 0;
      m_ram_pg = 0;
    end else if (reg_sel_i) begin
      if (wr_i && addr_i[3:0] == 4'hE) m_rom_pg = wdata_i & 31;
      if (wr_i && addr_i[3:0] == 4'hF) m_ram_pg = wdata_i & 7;
    end else if (!drv_sel_i && ext_sel_i && wr_i && !addr_i[10]) begin
      m_ram[m_ram_pg * 1024 + (addr_i & 10'h3FF)] = wdata_i;
    end
  end

  task automatic fail(input string req, input int act, input int exp);
    miscompares++;
    $display("FAIL %s: actual 0x%0h expected 0x%0h (phase %s)", req, act, exp, phase);
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      int exp_d;
      string tag;
      int off;
      bit exp_we;
      off = int'(addr_i) & 10'h3FF;
      exp_d = 0;
      tag = "R11";
      exp_we = 1'b0;
      if (reg_sel_i) begin
        case (addr_i[3:0])
          4'hC: begin tag = "R8"; exp_d = 8'h10 | (dma_sw_i ? 8'h40 : 8'h00); end
          4'hE: begin tag = "R7"; exp_d = (7 << 5) | m_rom_pg; end
          4'hF: begin tag = "R9"; exp_d = m_ram_pg; end
          default: begin tag = "R9"; exp_d = 0; end
        endcase
      end else if (drv_sel_i) begin
        tag = "R2"; exp_d = rom_val(int'(addr_i[7:0]));
        if (rd_i && rom_addr_o != 15'(addr_i[7:0])) fail("R2", rom_addr_o, addr_i[7:0]);
      end else if (ext_sel_i && addr_i[10]) begin
        tag = "R4"; exp_d = rom_val(m_rom_pg * 1024 + off);
        if (rom_addr_o != 15'(m_rom_pg * 1024 + off)) fail("R4", rom_addr_o, m_rom_pg * 1024 + off);
      end else if (ext_sel_i) begin
        tag = "R3";
        exp_d = m_ram.exists(m_ram_pg * 1024 + off) ? m_ram[m_ram_pg * 1024 + off] : 0;
        exp_we = wr_i;
        if (ram_addr_o != 13'(m_ram_pg * 1024 + off)) fail("R3", ram_addr_o, m_ram_pg * 1024 + off);
      end
      if (!rd_i || (!reg_sel_i && !drv_sel_i && !ext_sel_i)) begin
        tag = "R11"; exp_d = 0;
      end
      vectors++;
      if (int'(rdata_o) != exp_d) fail({tag, "/", phase}, rdata_o, exp_d);
      if (ram_we_o != exp_we) fail({"R10/", phase}, ram_we_o, exp_we);
      if (exp_we && ram_wdata_o != wdata_i) fail("R10", ram_wdata_o, wdata_i);
    end
  end

  task automatic idle();
    @(posedge clk_i); #1;
    {rd_i, wr_i, reg_sel_i, drv_sel_i, ext_sel_i} = '0;
  endtask
  task automatic reg_wr(input int ofs, input int d);
    @(posedge clk_i); #1;
    {rd_i, wr_i, reg_sel_i, drv_sel_i, ext_sel_i} = 5'b01100;
    addr_i = 11'(ofs); wdata_i = 8'(d);
  endtask
  task automatic reg_rd(input int ofs);
    @(posedge clk_i); #1;
    {rd_i, wr_i, reg_sel_i, drv_sel_i, ext_sel_i} = 5'b10100;
    addr_i = 11'(ofs);
  endtask
  task automatic drv_rd(input int a);
    @(posedge clk_i); #1;
    {rd_i, wr_i, reg_sel_i, drv_sel_i, ext_sel_i} = 5'b10010;
    addr_i = 11'(a);
  endtask
  task automatic ext_rd(input int a);
    @(posedge clk_i); #1;
    {rd_i, wr_i, reg_sel_i, drv_sel_i, ext_sel_i} = 5'b10001;
    addr_i = 11'(a);
  endtask
  task automatic ext_wr(input int a, input int d);
    @(posedge clk_i); #1;
    {rd_i, wr_i, reg_sel_i, drv_sel_i, ext_sel_i} = 5'b01001;
    addr_i = 11'(a); wdata_i = 8'(d);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1: reset readback
    phase = "R1";
    reg_rd(14); reg_rd(15); ext_rd(12'h400); ext_rd(12'h7FF);
    // R8: DMA switch readback
    phase = "R8";
    dma_sw_i = 1'b0; reg_rd(12);
    dma_sw_i = 1'b1; reg_rd(12);
    // R2: driver window
    phase = "R2";
    for (int a = 0; a < 256; a += 17) drv_rd(a);
    drv_rd(255);
    // R5: ROM page load and truncation
    phase = "R5";
    reg_wr(14, 8'hFF); reg_rd(14); ext_rd(12'h400); ext_rd(12'h5A5);
    reg_wr(14, 8'hE5); reg_rd(14);
    for (int p = 0; p < 32; p += 3) begin
      reg_wr(14, p); ext_rd(12'h400 + p * 13); reg_rd(14);
    end
    // R6: RAM page load and truncation
    phase = "R6";
    reg_wr(15, 8'hFA); reg_rd(15);
    reg_wr(15, 8'h07); reg_rd(15);
    // R3: per-page write and read-back
    phase = "R3";
    for (int p = 0; p < 8; p++) begin
      reg_wr(15, p);
      ext_wr(0, 8'h30 + p); ext_wr(10'h3FF, 8'hC0 + p); ext_wr(p * 100, p * 9 + 1);
    end
    for (int p = 7; p >= 0; p--) begin
      reg_wr(15, p);
      ext_rd(0); ext_rd(10'h3FF); ext_rd(p * 100); ext_rd(5);
    end
    // R10: writes into the ROM page are ignored
    phase = "R10";
    reg_wr(15, 2); reg_wr(14, 9);
    ext_wr(12'h400, 8'h99); ext_wr(12'h7FF, 8'h77);
    ext_rd(0); ext_rd(10'h3FF); ext_rd(12'h400); reg_rd(14); reg_rd(15);
    // R12: other register offsets do not touch the pages
    phase = "R12";
    for (int o = 0; o < 14; o++) reg_wr(o, 8'hFF);
    reg_rd(14); reg_rd(15);
    for (int o = 0; o < 14; o++) reg_rd(o);
    // R11: no read strobe
    phase = "R11";
    @(posedge clk_i); #1; {rd_i, wr_i, reg_sel_i, drv_sel_i, ext_sel_i} = 5'b00100; addr_i = 11'd14;
    @(posedge clk_i); #1; {rd_i, wr_i, reg_sel_i, drv_sel_i, ext_sel_i} = 5'b00010;
    @(posedge clk_i); #1; {rd_i, wr_i, reg_sel_i, drv_sel_i, ext_sel_i} = 5'b10000;
    idle(); idle();
    // R1: reset again restores defaults
    phase = "R1";
    @(posedge clk_i); #1 rst_ni = 1'b0;
    @(posedge clk_i); #1 rst_ni = 1'b1;
    reg_rd(14); reg_rd(15); idle();
    @(negedge clk_i); #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not complete)");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule